// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block produces the clock waveform of an I2C master and tells the surrounding bit logic when to change SDA. A prescaler divides the kernel clock into a timing tick. Tick counts set the low time, the high time, how long SDA is held after SCL falls and how long SDA is set up before SCL is released. The line level seen on the bus comes back through a synchronizer. Each phase is timed only after the generator has seen the bus actually reach that level. A slave that holds SCL low therefore stretches the high phase, and the synchronizer latency adds to the real period.

Six states run the block. IDLE leaves SCL released. IDLE goes to PULL when a bit is requested. PULL drives SCL low and goes to HOLD once the synchronized line reads low. HOLD goes to SETUP in the cycle the SDA update strobe fires. HOLD or SETUP go to WAIT_HIGH in the cycle the release strobe fires. WAIT_HIGH goes to HIGH once the synchronized line reads high. HIGH goes back to PULL when another bit is requested, and to IDLE when none is. Dropping the enable sends every state to IDLE.

The five timing fields are copied into the block only while it is idle. A burst of bits always runs with the values present when it started.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and whenever the enable is low or no bit is requested while idle, `scl_pull_o` is 0 and neither strobe fires.
- R2: With `scl_i` following the pulled line and the default 2-stage synchronizer, each low phase keeps `scl_pull_o` at 1 for exactly 3 + (D+1)·max(L+1, A+B+1) kernel cycles. Here D is `tick_div_i`, L is `lo_len_i`, A is `hold_dly_i` and B is `setup_dly_i`. A tick is D+1 kernel cycles.
- R3: `sda_upd_o` fires exactly once per low phase. It fires 3 + A·(D+1) cycles after `scl_pull_o` rises, so A = 0 means the first counted cycle.
- R4: `scl_rel_o` fires exactly once per low phase, in the last cycle that `scl_pull_o` is 1. It fires at least (B+1)·(D+1)−1 cycles after the update strobe cycle.
- R5: Between two bits of a burst, SCL stays released for exactly 3 + S + (H+1)·(D+1) cycles. H is `hi_len_i` and S is the number of extra cycles the bus holds `scl_i` low after release.
- R6: The high count starts only after the synchronized line reads high, so holding `scl_i` low stretches the high phase cycle for cycle.
- R7: `bit_req_i` is looked at when a high phase ends. If it is 1 a new low phase begins; if it is 0 the block returns to idle with SCL released and starts no further low phase.
- R8: Dropping `en_i` releases SCL in the next cycle and clears all counters. A later start runs a full-length low phase.
- R9: The timing fields are captured only while idle. Changing them during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Generator enable |
| bit_req_i | input | 1 | A further bit is wanted on the bus |
| tick_div_i | input | DIV_W | Prescaler value; tick = value+1 kernel cycles |
| lo_len_i | input | LO_W | Low phase length in ticks, minus one |
| hi_len_i | input | HI_W | High phase length in ticks, minus one |
| hold_dly_i | input | DLY_W | SDA hold delay in ticks after SCL is seen low |
| setup_dly_i | input | DLY_W | SDA setup delay in ticks, minus one |
| scl_i | input | 1 | SCL level observed on the bus |
| scl_pull_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_upd_o | output | 1 | One-cycle strobe: place the next SDA bit |
| scl_rel_o | output | 1 | One-cycle strobe in the last pulled cycle |

## Verification
The bench goes after the zero-length corners first. With a prescaler of 0, a hold of 0 and a setup of 0, both strobes land in the same single counted cycle; a design that ordered HOLD and SETUP rigidly would stretch that low phase by a cycle or drop the release strobe. A setup delay longer than the programmed low time must lengthen the low phase; a design that let the low count win would release SCL before the setup delay had run out. Holding the bus low after release must lengthen the high phase one for one, where a free-running high counter would shorten it. Two more runs check field changes in mid-burst and an enable dropped in mid-phase: a design that resampled the fields would change the phase lengths, and one that kept its counters would start short after re-enable.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULL,
        ST_HOLD,
        ST_SETUP,
        ST_WAITHI,
        ST_HIGH
    } tg_state_e;

endpackage

// File: rtl/scl_tg_sync.sv
module scl_tg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    // The line idles high, so the chain resets to ones.
    if (STAGES == 1) begin : g_single
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= '1;
            else         chain_q <= d_i;
        end
    end else begin : g_chain
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= '1;
            else         chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/scl_tg_ticker.sv
module scl_tg_ticker #(
    parameter int DIV_W = 4,
    parameter int CNT_W = 9
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o,
    output logic [CNT_W-1:0] ticks_o
);

    logic [DIV_W-1:0] pre_q;

    assign tick_o = !clr_i && (pre_q == div_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pre_q   <= '0;
            ticks_o <= '0;
        end else if (clr_i) begin
            pre_q   <= '0;
            ticks_o <= '0;
        end else if (tick_o) begin
            pre_q   <= '0;
            ticks_o <= ticks_o + CNT_W'(1);
        end else begin
            pre_q   <= pre_q + DIV_W'(1);
        end
    end

    // R2
    pre_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |-> (pre_q <= div_i));

    // R2
    tick_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && !clr_i) |=> (pre_q == '0));

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_tg_pkg::*;
#(
    parameter int DIV_W       = 4,
    parameter int LO_W        = 8,
    parameter int HI_W        = 8,
    parameter int DLY_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             bit_req_i,
    input  logic [DIV_W-1:0] tick_div_i,
    input  logic [LO_W-1:0]  lo_len_i,
    input  logic [HI_W-1:0]  hi_len_i,
    input  logic [DLY_W-1:0] hold_dly_i,
    input  logic [DLY_W-1:0] setup_dly_i,
    input  logic             scl_i,
    output logic             scl_pull_o,
    output logic             sda_upd_o,
    output logic             scl_rel_o
);

    localparam int PH_W = (LO_W > HI_W) ? LO_W : HI_W;
    localparam int MX_W = (PH_W > DLY_W + 1) ? PH_W : DLY_W + 1;
    localparam int CW   = MX_W + 1;

    tg_state_e state_q, state_d;

    logic [DIV_W-1:0] div_q;
    logic [LO_W-1:0]  lo_q;
    logic [HI_W-1:0]  hi_q;
    logic [DLY_W-1:0] hold_q;
    logic [DLY_W-1:0] setup_q;

    logic          scl_seen;
    logic          tick;
    logic          tick_clr;
    logic [CW-1:0] ticks;
    logic [CW-1:0] dly_sum;
    logic [CW-1:0] lo_last;
    logic          hold_hit;
    logic          low_done;
    logic          high_done;

    scl_tg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (scl_i),
        .q_o    (scl_seen)
    );

    // Tick counting restarts on every entry to the low or high phase.
    assign tick_clr = !(state_q == ST_HOLD || state_q == ST_SETUP || state_q == ST_HIGH);

    scl_tg_ticker #(.DIV_W(DIV_W), .CNT_W(CW)) u_ticker (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (tick_clr),
        .div_i   (div_q),
        .tick_o  (tick),
        .ticks_o (ticks)
    );

    // Fields follow the inputs only while idle.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            div_q   <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            hold_q  <= '0;
            setup_q <= '0;
        end else if (state_q == ST_IDLE) begin
            div_q   <= tick_div_i;
            lo_q    <= lo_len_i;
            hi_q    <= hi_len_i;
            hold_q  <= hold_dly_i;
            setup_q <= setup_dly_i;
        end
    end

    // Last tick index of the low phase: the longer of the low time and hold plus setup.
    assign dly_sum   = CW'(hold_q) + CW'(setup_q);
    assign lo_last   = (CW'(lo_q) > dly_sum) ? CW'(lo_q) : dly_sum;
    assign hold_hit  = (ticks == CW'(hold_q));
    assign low_done  = tick && (ticks == lo_last);
    assign high_done = tick && (ticks == CW'(hi_q));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (bit_req_i) state_d = ST_PULL;
            ST_PULL:   if (!scl_seen) state_d = ST_HOLD;
            ST_HOLD: begin
                if (low_done)      state_d = ST_WAITHI;
                else if (hold_hit) state_d = ST_SETUP;
            end
            ST_SETUP:  if (low_done) state_d = ST_WAITHI;
            ST_WAITHI: if (scl_seen) state_d = ST_HIGH;
            ST_HIGH:   if (high_done) state_d = bit_req_i ? ST_PULL : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
        if (!en_i) state_d = ST_IDLE;
    end

    always_comb begin
        scl_pull_o = (state_q == ST_PULL) || (state_q == ST_HOLD) || (state_q == ST_SETUP);
        sda_upd_o  = en_i && (state_q == ST_HOLD) && hold_hit;
        scl_rel_o  = en_i && (state_q == ST_HOLD || state_q == ST_SETUP) && low_done;
    end

    // R8
    disable_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !scl_pull_o);

    // R4
    rel_then_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        scl_rel_o |=> !scl_pull_o);

    // R3
    upd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sda_upd_o |=> !sda_upd_o);

    // R4
    strobe_in_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sda_upd_o || scl_rel_o) |-> scl_pull_o);

    // R6
    high_after_seen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_HIGH && $past(state_q) == ST_WAITHI) |-> $past(scl_seen));

    // R9
    fields_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |->
        ($stable(div_q) && $stable(lo_q) && $stable(hi_q) && $stable(hold_q) && $stable(setup_q)));

endmodule

// File: tb/scl_timing_gen_test.sv
module scl_timing_gen_test;

    typedef struct {
        int kind;   // 0 low phase, 1 high phase
        int len;
        int upd;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       bit_req = 1'b0;
    logic [3:0] div = '0;
    logic [7:0] lo = '0;
    logic [7:0] hi = '0;
    logic [3:0] hold = '0;
    logic [3:0] setup = '0;
    logic       scl_line;
    logic       pull, upd, rel;

    int    stretch_n = 0;
    int    hold_left = 0;
    int    vectors = 0;
    int    miscompares = 0;
    int    upd_total = 0;
    bit    mon_on = 1'b1;
    item_t expq[$];
    item_t cur;

    assign scl_line = !(pull || hold_left > 0);

    always #2 clk = ~clk;

    scl_timing_gen uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .en_i        (en),
        .bit_req_i   (bit_req),
        .tick_div_i  (div),
        .lo_len_i    (lo),
        .hi_len_i    (hi),
        .hold_dly_i  (hold),
        .setup_dly_i (setup),
        .scl_i       (scl_line),
        .scl_pull_o  (pull),
        .sda_upd_o   (upd),
        .scl_rel_o   (rel)
    );

    task automatic chk(bit ok, string req, string what, int act, int expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Monitor: measures every phase and compares against the queued expectations.
    bit prev_low = 1'b0;
    int low_len = 0, hi_len = 0, upd_pos = 0, upd_cnt = 0, rel_pos = 0, rel_cnt = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_low && !pull) hold_left = stretch_n;
            else if (hold_left > 0) hold_left--;
            if (pull) begin
                if (!prev_low) begin
                    if (mon_on && expq.size() > 0 && expq[0].kind == 1) begin
                        cur = expq.pop_front();
                        chk(hi_len == cur.len, "R5", "released length", hi_len, cur.len);
                    end
                    low_len = 0; upd_cnt = 0; rel_cnt = 0; upd_pos = -1; rel_pos = -1;
                end
                if (upd) begin upd_cnt++; upd_pos = low_len; upd_total++; end
                if (rel) begin rel_cnt++; rel_pos = low_len; end
                low_len++;
            end else begin
                if (prev_low) begin
                    if (mon_on) begin
                        if (expq.size() == 0 || expq[0].kind != 0) begin
                            chk(1'b0, "R7", "unexpected low phase", low_len, 0);
                        end else begin
                            cur = expq.pop_front();
                            chk(low_len == cur.len, "R2", "low length", low_len, cur.len);
                            chk(upd_pos == cur.upd, "R3", "update position", upd_pos, cur.upd);
                            chk(upd_cnt == 1, "R3", "update count", upd_cnt, 1);
                            chk(rel_pos == low_len - 1, "R4", "release position", rel_pos, low_len - 1);
                            chk(rel_cnt == 1, "R4", "release count", rel_cnt, 1);
                        end
                    end
                    hi_len = 0;
                end
                if (upd || rel) chk(1'b0, "R1", "strobe while released", 1, 0);
                hi_len++;
            end
            prev_low = pull;
        end
    end

    // Driver: programs a burst and queues the phases the requirements predict.
    task automatic burst(int p, int l, int h, int d, int s, int n, int str, bit chg);
        int r;
        int base;
        int guard;
        r = (l + 1 > d + s + 1) ? l + 1 : d + s + 1;
        @(negedge clk);
        div = 4'(p); lo = 8'(l); hi = 8'(h); hold = 4'(d); setup = 4'(s);
        stretch_n = str;
        for (int i = 0; i < n; i++) begin
            expq.push_back('{0, 3 + r * (p + 1), 3 + d * (p + 1)});
            if (i < n - 1) expq.push_back('{1, 3 + str + (h + 1) * (p + 1), 0});
        end
        base = upd_total;
        en = 1'b1;
        bit_req = 1'b1;
        while (upd_total < base + n) begin
            @(negedge clk);
            // R9: scramble the fields once the burst is under way
            if (chg && upd_total == base + 1) begin
                div = 4'd0; lo = 8'd1; hi = 8'd0; hold = 4'd0; setup = 4'd0;
            end
        end
        bit_req = 1'b0;
        guard = 0;
        while (expq.size() > 0 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3 + str + (h + 1) * (p + 1) + 12) @(negedge clk);
        // R7: no further low phase once the request is withdrawn
        chk(!pull, "R7", "line released after last bit", int'(pull), 0);
        chk(expq.size() == 0, "R7", "phases left unmatched", expq.size(), 0);
    endtask

    initial begin
        #600000;
        vectors++;
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int act;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!pull && !upd && !rel, "R1", "outputs after reset", int'({pull, upd, rel}), 0);

        en = 1'b1;
        bit_req = 1'b0;
        act = 0;
        repeat (20) begin @(negedge clk); if (pull || upd || rel) act++; end
        chk(act == 0, "R1", "activity with no request", act, 0);

        en = 1'b0;
        bit_req = 1'b1;
        act = 0;
        repeat (20) begin @(negedge clk); if (pull || upd || rel) act++; end
        chk(act == 0, "R1", "activity while disabled", act, 0);
        bit_req = 1'b0;

        burst(0, 3, 1, 0, 0, 3, 0, 1'b0);     // R2 R3 R4: zero hold and setup
        burst(2, 4, 3, 2, 1, 2, 0, 1'b0);     // R2: low time dominates
        burst(1, 1, 2, 3, 4, 2, 0, 1'b0);     // R4: setup dominates the low phase
        burst(0, 0, 0, 0, 0, 3, 0, 1'b0);     // R3 R4: both strobes in one cycle
        burst(1, 3, 2, 1, 1, 3, 7, 1'b0);     // R6: bus held low after release
        burst(3, 5, 4, 1, 2, 3, 0, 1'b1);     // R9: fields changed mid-burst
        burst(11, 199, 195, 2, 4, 2, 0, 1'b0); // R2 R5: slow bus settings

        // R8: drop the enable in the middle of a low phase
        mon_on = 1'b0;
        @(negedge clk);
        div = 4'd1; lo = 8'd20; hi = 8'd5; hold = 4'd2; setup = 4'd1;
        stretch_n = 0;
        en = 1'b1;
        bit_req = 1'b1;
        act = 0;
        while (!pull && act < 100) begin @(negedge clk); act++; end
        repeat (10) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk(!pull, "R8", "line after disable", int'(pull), 0);
        act = 0;
        repeat (20) begin @(negedge clk); if (pull || upd || rel) act++; end
        chk(act == 0, "R8", "activity after disable", act, 0);
        bit_req = 1'b0;
        repeat (5) @(negedge clk);
        mon_on = 1'b1;
        burst(1, 20, 5, 2, 1, 1, 0, 1'b0);    // R8: full-length phase after re-enable

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule